// File: doc/BRIEF.md
# Per-Core Job Sequence Tracker

This block tracks which jobs are outstanding on each of the NCORES hashing cores of one chip. An accepted job is given a chip-wide issue number, which counts up from 1 after reset, and an 8-bit sequence tag drawn from that core's own counter. For each core the block keeps the issue numbers of the two most recent jobs. A core holds at most one job waiting behind its active one. A second job sent to a core whose pending flag is set is refused, and that core's queue-full flag is raised.

The chip reports status through a lookup. The lookup carries a 16-bit tag and a field of two status bits per core. The tag resolves to an issue number, either the core's latest job or the one before it. Any core whose status shows no pending job, and whose latest issue number does not exceed the resolved number, has its pending and queue-full flags cleared. The lookup outputs are combinational on the current tag. All flag and counter changes take effect at the next rising clock edge.

Top module: `job_seq_tracker`

## Requirements
- R1: After reset all pending and queue-full flags are 0, every sequence counter and stored issue number is 0, and the first accepted job gets tag 1 and issue number 1.
- R2: An issue to a core that is in range and not pending is accepted in the same cycle (`issue_ack`=1). `issue_tag` shows that core's sequence plus 1 (mod 256) and `issue_num` shows the chip issue number plus 1. At the next edge both counters advance and the core's pending flag is set.
- R3: On an accepted issue, the core's previous latest issue number moves to its second-latest slot, and the new number becomes the latest.
- R4: An issue to a core whose pending flag is set is refused (`issue_ack`=0) and changes no counter. The core's queue-full flag is set at the next edge.
- R5: In `lookup_tag`, bits [15:8] select the core and bits [7:0] carry the sequence number.
- R6: If the selected core's sequence counter equals the tag sequence, the lookup reports a hit and returns the core's latest issue number.
- R7: If the counter equals the tag sequence plus 1, with 8-bit wraparound (tag 255 matches counter 0), the lookup reports a hit and returns the second-latest issue number.
- R8: Any other tag sequence gives `lookup_hit`=0 and `lookup_isn`=0.
- R9: In `status_bits`, bit 2i is core i's active flag and bit 2i+1 is its pending flag. When `lookup_valid` is high, each core i whose status pending bit is 0 and whose latest issue number is at most `lookup_isn` has its pending and queue-full flags cleared at the next edge.
- R10: A core whose status pending bit is 1, or whose latest issue number exceeds `lookup_isn`, keeps its flags through a lookup.
- R11: A lookup whose core field is NCORES or more raises `lookup_err` for that cycle, returns a miss with issue number 0, and changes no flag.
- R12: An issue whose core is NCORES or more is not accepted and changes no state.
- R13: If a refused issue and a lookup that clears the same core happen in one cycle, the clear wins and queue-full stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Job issue request |
| issue_core | input | 8 | Target core of the issue |
| issue_ack | output | 1 | Issue accepted this cycle |
| issue_tag | output | 8 | Sequence tag the job receives |
| issue_num | output | ISN_W | Chip issue number the job receives |
| lookup_valid | input | 1 | Status lookup strobe |
| lookup_tag | input | 16 | Core in [15:8], sequence in [7:0] |
| status_bits | input | 2*NCORES | Per core: active at 2i, pending at 2i+1 |
| lookup_hit | output | 1 | Tag matched one of the two recent jobs |
| lookup_isn | output | ISN_W | Resolved issue number, 0 on a miss |
| lookup_err | output | 1 | Lookup core out of range |
| pending | output | NCORES | Per-core pending flag |
| queue_full | output | NCORES | Per-core refused-issue flag |

## Verification
The bench builds the block with NCORES=6 and ISN_W=16. With six cores the status field is twelve bits wide, which is not a whole number of bytes, and core codes 6 and 7 fall inside an 8-bit core field, so both out-of-range paths can be reached. One core is driven through more than 256 issues so that its sequence counter wraps and the second-latest match is taken across the wrap. A long stretch of random issues, tags and status fields is then checked against the model cycle by cycle.

// File: rtl/job_seq_tracker.sv
module job_seq_tracker #(
  parameter int NCORES = 8,
  parameter int ISN_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue_valid,
  input  logic [7:0]            issue_core,
  output logic                  issue_ack,
  output logic [7:0]            issue_tag,
  output logic [ISN_W-1:0]      issue_num,
  input  logic                  lookup_valid,
  input  logic [15:0]           lookup_tag,
  input  logic [2*NCORES-1:0]   status_bits,
  output logic                  lookup_hit,
  output logic [ISN_W-1:0]      lookup_isn,
  output logic                  lookup_err,
  output logic [NCORES-1:0]     pending,
  output logic [NCORES-1:0]     queue_full
);

  logic [ISN_W-1:0] chip_isn;
  logic [7:0]       seq_q  [NCORES];
  logic [ISN_W-1:0] last_q [NCORES];
  logic [ISN_W-1:0] prev_q [NCORES];
  logic [NCORES-1:0] pend_q, full_q, clr;

  logic             i_ok, i_pend, l_ok;
  logic [7:0]       i_seq, l_seq;
  logic [ISN_W-1:0] l_last, l_prev;
  logic             hit_last, hit_prev;
  logic [NCORES-1:0] unused_active;

  always_comb begin
    i_ok = 1'b0; i_pend = 1'b0; i_seq = '0;
    l_ok = 1'b0; l_seq = '0; l_last = '0; l_prev = '0;
    for (int i = 0; i < NCORES; i++) begin
      if (issue_core == 8'(i)) begin
        i_ok = 1'b1; i_pend = pend_q[i]; i_seq = seq_q[i];
      end
      if (lookup_tag[15:8] == 8'(i)) begin
        l_ok = 1'b1; l_seq = seq_q[i]; l_last = last_q[i]; l_prev = prev_q[i];
      end
    end
  end

  assign issue_ack = issue_valid & i_ok & ~i_pend;
  assign issue_tag = i_seq + 8'd1;
  assign issue_num = chip_isn + 1'b1;

  assign hit_last   = l_ok & (l_seq == lookup_tag[7:0]);
  assign hit_prev   = l_ok & ~hit_last & (l_seq == lookup_tag[7:0] + 8'd1);
  assign lookup_hit = hit_last | hit_prev;
  assign lookup_isn = hit_last ? l_last : (hit_prev ? l_prev : '0);
  assign lookup_err = lookup_valid & ~l_ok;

  always_comb begin
    for (int i = 0; i < NCORES; i++) begin
      clr[i] = lookup_valid & l_ok & ~status_bits[2*i+1] & (last_q[i] <= lookup_isn);
      unused_active[i] = status_bits[2*i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chip_isn <= '0;
      pend_q   <= '0;
      full_q   <= '0;
      for (int i = 0; i < NCORES; i++) begin
        seq_q[i]  <= '0;
        last_q[i] <= '0;
        prev_q[i] <= '0;
      end
    end else begin
      if (issue_ack) chip_isn <= issue_num;
      for (int i = 0; i < NCORES; i++) begin
        if (clr[i]) begin
          pend_q[i] <= 1'b0;
          full_q[i] <= 1'b0;
        end
        if (issue_valid && issue_core == 8'(i)) begin
          if (pend_q[i]) begin
            if (!clr[i]) full_q[i] <= 1'b1;
          end else begin
            seq_q[i]  <= seq_q[i] + 8'd1;
            prev_q[i] <= last_q[i];
            last_q[i] <= issue_num;
            pend_q[i] <= 1'b1;
          end
        end
      end
    end
  end

  assign pending    = pend_q;
  assign queue_full = full_q;

  assert_isn_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ack |=> chip_isn == ISN_W'($past(chip_isn) + 1'b1));

  assert_err_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_err |-> (!lookup_hit && lookup_isn == '0));

  assert_err_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_err && !issue_valid) |=> $stable(pend_q) && $stable(full_q));

  for (genvar g = 0; g < NCORES; g++) begin : g_chk
    assert_accept_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_ack && issue_core == 8'(g)) |=> pend_q[g]);
    assert_refuse_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_core == 8'(g) && pend_q[g] && !lookup_valid) |=> full_q[g]);
    assert_full_needs_pend_R13: assert property (@(posedge clk) disable iff (!rst_n)
      full_q[g] |-> pend_q[g]);
    assert_clear_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[g]) |-> $past(lookup_valid && !status_bits[2*g+1]));
  end

endmodule

// File: tb/job_seq_tracker_test.sv
module job_seq_tracker_test;
  localparam int NC = 6;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [7:0] issue_core = '0;
  logic issue_ack;
  logic [7:0] issue_tag;
  logic [IW-1:0] issue_num;
  logic lookup_valid = 1'b0;
  logic [15:0] lookup_tag = '0;
  logic [2*NC-1:0] status_bits = '0;
  logic lookup_hit;
  logic [IW-1:0] lookup_isn;
  logic lookup_err;
  logic [NC-1:0] pending, queue_full;

  job_seq_tracker #(.NCORES(NC), .ISN_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_core(issue_core),
    .issue_ack(issue_ack), .issue_tag(issue_tag), .issue_num(issue_num),
    .lookup_valid(lookup_valid), .lookup_tag(lookup_tag), .status_bits(status_bits),
    .lookup_hit(lookup_hit), .lookup_isn(lookup_isn), .lookup_err(lookup_err),
    .pending(pending), .queue_full(queue_full));

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int m_chip;
  int m_seq [NC];
  int m_last[NC];
  int m_prev[NC];
  bit m_pend[NC];
  bit m_full[NC];
  bit e_ack, e_hit, e_err;
  int e_tag, e_num, e_isn;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_chip = 0;
    for (int i = 0; i < NC; i++) begin
      m_seq[i] = 0; m_last[i] = 0; m_prev[i] = 0; m_pend[i] = 0; m_full[i] = 0;
    end
  endtask

  task automatic model_comb();
    int ic, lc, ls;
    ic = issue_core; lc = lookup_tag[15:8]; ls = lookup_tag[7:0];
    e_ack = issue_valid && ic < NC && !m_pend[ic < NC ? ic : 0];
    e_tag = ic < NC ? (m_seq[ic] + 1) % 256 : 1;
    e_num = (m_chip + 1) % 65536;
    e_hit = 0; e_isn = 0;
    if (lc < NC) begin
      if (m_seq[lc] == ls) begin e_hit = 1; e_isn = m_last[lc]; end
      else if (m_seq[lc] == (ls + 1) % 256) begin e_hit = 1; e_isn = m_prev[lc]; end
    end
    e_err = lookup_valid && lc >= NC;
  endtask

  task automatic model_tick();
    bit c[NC];
    int ic;
    model_comb();
    ic = issue_core;
    for (int i = 0; i < NC; i++)
      c[i] = lookup_valid && lookup_tag[15:8] < NC && !status_bits[2*i+1] && m_last[i] <= e_isn;
    for (int i = 0; i < NC; i++)
      if (c[i]) begin m_pend[i] = 0; m_full[i] = 0; end
    if (issue_valid && ic < NC) begin
      if (e_ack) begin
        m_seq[ic] = (m_seq[ic] + 1) % 256;
        m_prev[ic] = m_last[ic];
        m_last[ic] = e_num;
        m_pend[ic] = 1;
        m_chip = e_num;
      end else if (!c[ic]) m_full[ic] = 1;
    end
  endtask

  task automatic compare_all();
    model_comb();
    chk("R2 ack", issue_ack, e_ack);
    if (issue_core < NC) chk("R2 tag", issue_tag, e_tag);
    chk("R2 num", issue_num, e_num);
    chk("R6 hit", lookup_hit, e_hit);
    chk("R6 isn", lookup_isn, e_isn);
    chk("R11 err", lookup_err, e_err);
    for (int i = 0; i < NC; i++) begin
      chk("R9 pending", pending[i], m_pend[i]);
      chk("R4 queue_full", queue_full[i], m_full[i]);
    end
  endtask

  task automatic drive(input bit iv, input int ic, input bit lv, input int lc, input int ls,
                       input logic [2*NC-1:0] st);
    issue_valid = iv; issue_core = 8'(ic);
    lookup_valid = lv; lookup_tag = {8'(lc), 8'(ls)}; status_bits = st;
    #1;
    compare_all();
  endtask

  task automatic tick();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    issue_valid = 0; lookup_valid = 0;
    #1;
    compare_all();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 pending", int'(pending), 0);
    chk("R1 queue_full", int'(queue_full), 0);
    @(negedge clk);

    drive(1, 2, 0, 0, 0, '0);
    chk("R1 first ack", issue_ack, 1);
    chk("R1 first tag", issue_tag, 1);
    chk("R1 first num", issue_num, 1);
    tick();
    chk("R2 pending set", pending[2], 1);

    drive(1, 2, 0, 0, 0, '0);
    chk("R4 refused", issue_ack, 0);
    tick();
    chk("R4 full set", queue_full[2], 1);
    chk("R4 still pending", pending[2], 1);

    drive(0, 0, 1, 2, 1, '0);
    chk("R5 R6 hit", lookup_hit, 1);
    chk("R6 isn", lookup_isn, 1);
    tick();
    chk("R9 pending cleared", pending[2], 0);
    chk("R9 full cleared", queue_full[2], 0);

    drive(1, 2, 0, 0, 0, '0);
    chk("R2 second tag", issue_tag, 2);
    chk("R2 second num", issue_num, 2);
    tick();
    drive(1, 0, 0, 0, 0, '0);
    chk("R2 core0 tag", issue_tag, 1);
    chk("R2 core0 num", issue_num, 3);
    tick();

    drive(0, 0, 1, 2, 1, 12'b0000_0010_0000);
    chk("R3 R7 prev hit", lookup_hit, 1);
    chk("R3 R7 prev isn", lookup_isn, 1);
    tick();
    chk("R10 status pending keeps", pending[2], 1);
    chk("R10 newer isn keeps", pending[0], 1);

    drive(0, 0, 1, 2, 7, '0);
    chk("R8 miss", lookup_hit, 0);
    chk("R8 isn zero", lookup_isn, 0);
    tick();

    drive(0, 0, 1, 7, 0, '0);
    chk("R11 err", lookup_err, 1);
    chk("R11 miss", lookup_hit, 0);
    tick();
    chk("R11 no clear", pending[0], 1);

    drive(1, 9, 0, 0, 0, '0);
    chk("R12 no ack", issue_ack, 0);
    tick();
    drive(1, 1, 0, 0, 0, '0);
    chk("R12 chip unchanged", issue_num, 4);
    tick();

    drive(1, 2, 1, 2, 2, '0);
    chk("R13 refused", issue_ack, 0);
    tick();
    chk("R13 pending cleared", pending[2], 0);
    chk("R13 full stays low", queue_full[2], 0);

    for (int k = 0; k < 256; k++) begin
      drive(1, 3, 0, 0, 0, '0);
      tick();
      drive(0, 0, 1, 3, m_seq[3], 12'b1111_0011_1111);
      tick();
    end
    drive(0, 0, 1, 3, 255, '0);
    chk("R7 wrap hit", lookup_hit, 1);
    chk("R7 wrap isn", lookup_isn, m_prev[3]);
    tick();

    for (int k = 0; k < 1500; k++) begin
      int lc;
      lc = $urandom_range(0, 7);
      drive($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 1), lc,
            (lc < NC) ? (m_seq[lc] - 1 + $urandom_range(0, 2)) % 256 : $urandom_range(0, 255),
            12'($urandom));
      tick();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule